// File: doc/BRIEF.md
# Debounced Key Matrix Scanner

This block scans a key matrix of six drive lines and five sense lines, which gives up to thirty keys. It runs on the system clock and advances only on an oscillator tick enable. While it is idle it holds the drive lines at a standby pattern. A key that joins a high drive line to a sense line starts a scan. The scan raises each drive line alone, one after the other, and does the whole sweep twice. A capture is accepted only when the second sweep reads exactly the same thirty bits as the first and at least one key is down. An accepted capture is latched into the key buffer, and an active-low ready flag is pulled low for the host.

After a capture the buffer stays frozen and no scan can start until the serial side strobes `read_done`, which it does once the last key bit has been shifted out. A mismatch or a release during the scan drops the result. The block then goes back to idle, and it scans again at once if a key is still held. In the sleep modes only some drive lines are high at standby, so only keys on those lines can wake the part. A wake request output asks for the oscillator to run from the moment such a key is seen until the scan ends. Two drive lines can be handed over to segment duty, and they are then neither driven nor scanned.

Top module: `keymat_scanner`

## Requirements
- R1: A scan takes SCAN_TICKS = 1 + 2·LINES·SLOT_TICKS + TAIL_TICKS oscillator ticks. The count starts with the tick on which a pressed key is seen in idle and ends with the tick after which `key_ready_n` falls. A press that is released before the second sweep samples it produces no capture.
- R2: During a sweep exactly one enabled drive line is high. Line 1 to line 6 are driven in order for SLOT_TICKS ticks each, the sweep is done twice, and all drive lines are low during the TAIL_TICKS closing ticks. The sense inputs are sampled at tick SETTLE_TICKS of each slot.
- R3: When the two sweeps differ, nothing is captured and the block returns to idle. If a key is still held, a new scan starts on the next tick, so a capture whose second scan succeeds arrives 2·SCAN_TICKS ticks after the press.
- R4: When both sweeps match and are not all zero, the image is loaded into `key_image` and `key_ready_n` goes low.
- R5: While `key_ready_n` is low, no scan starts and `key_image` does not change, whatever the keys do.
- R6: A `read_done` pulse while `key_ready_n` is low sets it high, and scanning may then resume. A pulse while it is already high has no effect.
- R7: The key on drive line L (1..6) and sense line S (1..5) appears at `key_image` bit 5·(L−1)+(S−1).
- R8: The idle drive pattern depends on `sleep_sel`. With 0 or 3 all lines are high, with 1 only line 6 is high, and with 2 only lines 5 and 6 are high.
- R9: `wake_req` is high when `sleep_sel` ≠ 0 and either a scan is running or a key on a high standby line is seen while not locked. It is always low when `sleep_sel` = 0.
- R10: `line_cfg` = 0 enables all six lines. A value of 1 takes line 1 out of service, and 2 or 3 take lines 1 and 2 out. A line out of service has `drive_en` and `drive_out` low, and its keys never appear.
- R11: Reset clears `key_image`, sets `key_ready_n` high and returns to the idle pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | One-cycle oscillator tick enable |
| sleep_sel | input | 2 | Sleep mode select (0 normal, 1..3 sleep) |
| line_cfg | input | 2 | Drive lines handed to segment duty |
| read_done | input | 1 | Key data fully read by the serial side |
| sense_in | input | SENSES | Matrix sense inputs |
| drive_out | output | LINES | Matrix drive levels |
| drive_en | output | LINES | Drive line in key-scan service |
| key_image | output | LINES·SENSES | Latched key buffer |
| key_ready_n | output | 1 | Active-low capture ready (interrupt) |
| wake_req | output | 1 | Oscillator run request in sleep |

## Verification
The hardest case to reach is the retry. The first scan must fail only because a key changed between the two sweeps, the keys must stay held, and the second scan must then succeed. The bench counts oscillator ticks from the press and adds a second key on the same drive line just after the first sweep has sampled that line. This forces a mismatch, and the tick count at capture must then equal exactly two scan lengths. Sleep wake-up is reached by gating the bench's tick source with `wake_req`, so a key on a low standby line leaves the block with no ticks at all.

// File: rtl/keymat_pkg.sv
// Shared types for the key matrix scanner.
package keymat_pkg;
    // Scan sequencer phase.
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_SCAN = 2'd1,
        SEQ_TAIL = 2'd2
    } seq_state_t;
endpackage

// File: rtl/keymat_sequencer.sv
// Scan sequencer: walks drive lines slot by slot for two sweeps, then a
// closing tail. Advances only on osc_tick. Assumes SETTLE_TICKS < SLOT_TICKS
// and TAIL_TICKS >= 1. 'start' is honoured only in idle.
module keymat_sequencer
    import keymat_pkg::*;
#(
    parameter int LINES        = 6,
    parameter int SLOT_TICKS   = 48,
    parameter int SETTLE_TICKS = 6,
    parameter int TAIL_TICKS   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     osc_tick,
    input  logic                     start,
    output seq_state_t               state,
    output logic [$clog2(LINES)-1:0] line_idx,
    output logic                     second_pass,
    output logic                     sample_stb,
    output logic                     finish_stb
);
    localparam int LW   = $clog2(LINES);
    localparam int MAXT = (SLOT_TICKS > TAIL_TICKS) ? SLOT_TICKS : TAIL_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [LW-1:0] LINE_LAST = LW'(LINES - 1);
    localparam logic [CW-1:0] SLOT_LAST = CW'(SLOT_TICKS - 1);
    localparam logic [CW-1:0] TAIL_LAST = CW'(TAIL_TICKS - 1);
    localparam logic [CW-1:0] SETTLE_AT = CW'(SETTLE_TICKS);

    logic [CW-1:0] cnt;

    // Phase, slot counter, line and sweep bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SEQ_IDLE;
            cnt         <= '0;
            line_idx    <= '0;
            second_pass <= 1'b0;
        end else if (osc_tick) begin
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state       <= SEQ_SCAN;
                        cnt         <= '0;
                        line_idx    <= '0;
                        second_pass <= 1'b0;
                    end
                end
                SEQ_SCAN: begin
                    if (cnt == SLOT_LAST) begin
                        cnt <= '0;
                        if (line_idx == LINE_LAST) begin
                            line_idx <= '0;
                            if (second_pass) state <= SEQ_TAIL;
                            else second_pass <= 1'b1;
                        end else begin
                            line_idx <= line_idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SEQ_TAIL: begin
                    if (cnt == TAIL_LAST) begin
                        cnt   <= '0;
                        state <= SEQ_IDLE;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Sense sampling point and end-of-scan strobe.
    always_comb begin
        sample_stb = osc_tick && (state == SEQ_SCAN) && (cnt == SETTLE_AT);
        finish_stb = osc_tick && (state == SEQ_TAIL) && (cnt == TAIL_LAST);
    end

    assert_line_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        line_idx <= LINE_LAST);
    assert_slot_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_SCAN && osc_tick && cnt != SLOT_LAST) |=> cnt == $past(cnt) + 1'b1);
    assert_frozen_without_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_tick |=> $stable(state) && $stable(line_idx));
endmodule

// File: rtl/keymat_drive.sv
// Drive pattern generator: standby levels per sleep mode in idle, one-hot
// scan line during sweeps, all low in the tail. Lines given to segment duty
// are masked. clk/rst_n serve only the local assertions.
module keymat_drive
    import keymat_pkg::*;
#(
    parameter int LINES = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  seq_state_t               state,
    input  logic [$clog2(LINES)-1:0] line_idx,
    input  logic [1:0]               sleep_sel,
    input  logic [1:0]               line_cfg,
    output logic [LINES-1:0]         drive_out,
    output logic [LINES-1:0]         drive_en
);
    localparam int LW = $clog2(LINES);

    logic [LINES-1:0] standby;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam logic [LW-1:0] G_IDX = LW'(g);
        // Service enable: the first two lines may be lent to segment duty.
        if (g == 0) begin : g_en0
            assign drive_en[g] = (line_cfg == 2'd0);
        end else if (g == 1) begin : g_en1
            assign drive_en[g] = !line_cfg[1];
        end else begin : g_enx
            assign drive_en[g] = 1'b1;
        end
        // Standby level: sleep modes 1 and 2 keep only the top lines armed.
        assign standby[g] = (sleep_sel == 2'd1) ? (g == LINES - 1) :
                            (sleep_sel == 2'd2) ? (g >= LINES - 2) : 1'b1;
        // Output level by phase.
        always_comb begin
            case (state)
                SEQ_SCAN: drive_out[g] = drive_en[g] && (line_idx == G_IDX);
                SEQ_TAIL: drive_out[g] = 1'b0;
                default:  drive_out[g] = drive_en[g] && standby[g];
            endcase
        end
    end

    assert_one_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == SEQ_SCAN |-> $onehot0(drive_out));
    assert_tail_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state == SEQ_TAIL |-> drive_out == '0);
    assert_lent_line_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        line_cfg != 2'd0 |-> !drive_out[0]);
endmodule

// File: rtl/keymat_capture.sv
// Sweep capture: the first sweep stores each line's sense bits, the second
// compares against them and flags any difference per line. Assumes the
// sequencer samples every line once per sweep, first sweep first.
module keymat_capture #(
    parameter int LINES  = 6,
    parameter int SENSES = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sample_stb,
    input  logic                     second_pass,
    input  logic [$clog2(LINES)-1:0] line_idx,
    input  logic [SENSES-1:0]        sense_in,
    output logic [LINES*SENSES-1:0]  image,
    output logic                     mismatch
);
    localparam int LW = $clog2(LINES);

    logic [LINES-1:0] line_err;

    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam logic [LW-1:0] G_IDX = LW'(g);
        logic [SENSES-1:0] slice_q;
        logic              err_q;
        logic              hit;
        assign hit = sample_stb && (line_idx == G_IDX);
        // First sweep stores, second sweep compares.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slice_q <= '0;
                err_q   <= 1'b0;
            end else if (hit) begin
                if (!second_pass) begin
                    slice_q <= sense_in;
                    err_q   <= 1'b0;
                end else begin
                    err_q <= (sense_in != slice_q);
                end
            end
        end
        assign image[g*SENSES +: SENSES] = slice_q;
        assign line_err[g] = err_q;
    end

    assign mismatch = |line_err;

    assert_image_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |=> $stable(image));
    assert_second_keeps_image_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_stb && second_pass) |=> $stable(image));
endmodule

// File: rtl/keymat_scanner.sv
// Key matrix scanner top: starts a double sweep when an idle key is seen,
// latches a matching non-empty result, holds it locked until read_done.
// Assumes osc_tick is a single-cycle enable and sense_in is synchronous.
module keymat_scanner
    import keymat_pkg::*;
#(
    parameter int LINES        = 6,
    parameter int SENSES       = 5,
    parameter int SLOT_TICKS   = 48,
    parameter int SETTLE_TICKS = 6,
    parameter int TAIL_TICKS   = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     osc_tick,
    input  logic [1:0]               sleep_sel,
    input  logic [1:0]               line_cfg,
    input  logic                     read_done,
    input  logic [SENSES-1:0]        sense_in,
    output logic [LINES-1:0]         drive_out,
    output logic [LINES-1:0]         drive_en,
    output logic [LINES*SENSES-1:0]  key_image,
    output logic                     key_ready_n,
    output logic                     wake_req
);
    localparam int KEYS = LINES * SENSES;
    localparam int LW   = $clog2(LINES);

    seq_state_t        state;
    logic [LW-1:0]     line_idx;
    logic              second_pass;
    logic              sample_stb;
    logic              finish_stb;
    logic              start;
    logic [KEYS-1:0]   image;
    logic              mismatch;

    assign start = key_ready_n && (|sense_in);

    keymat_sequencer #(
        .LINES(LINES), .SLOT_TICKS(SLOT_TICKS),
        .SETTLE_TICKS(SETTLE_TICKS), .TAIL_TICKS(TAIL_TICKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .start(start),
        .state(state), .line_idx(line_idx), .second_pass(second_pass),
        .sample_stb(sample_stb), .finish_stb(finish_stb)
    );

    keymat_drive #(.LINES(LINES)) u_drive (
        .clk(clk), .rst_n(rst_n), .state(state), .line_idx(line_idx),
        .sleep_sel(sleep_sel), .line_cfg(line_cfg),
        .drive_out(drive_out), .drive_en(drive_en)
    );

    keymat_capture #(.LINES(LINES), .SENSES(SENSES)) u_cap (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb),
        .second_pass(second_pass), .line_idx(line_idx),
        .sense_in(sense_in), .image(image), .mismatch(mismatch)
    );

    // Key buffer and lock: load on a clean non-empty result, unlock on read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_image   <= '0;
            key_ready_n <= 1'b1;
        end else if (finish_stb && !mismatch && (|image)) begin
            key_image   <= image;
            key_ready_n <= 1'b0;
        end else if (read_done && !key_ready_n) begin
            key_ready_n <= 1'b1;
        end
    end

    // Oscillator request while asleep: from key detection to end of scan.
    assign wake_req = (sleep_sel != 2'd0) && ((state != SEQ_IDLE) || start);

    assert_locked_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !key_ready_n |-> state == SEQ_IDLE);
    assert_buffer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !key_ready_n |=> $stable(key_image));
    assert_capture_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(key_ready_n) |-> key_image != '0);
    assert_no_wake_normal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_sel == 2'd0 |-> !wake_req);
    assert_release_on_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_ready_n) |-> $past(read_done));
endmodule

// File: tb/keymat_scanner_test.sv
module keymat_scanner_test;
    localparam int CLK_PERIOD = 10;
    localparam int LINES  = 6;
    localparam int SENSES = 5;
    localparam int SLOT   = 4;
    localparam int SETTLE = 2;
    localparam int TAIL   = 2;
    localparam int KEYS   = LINES * SENSES;
    localparam int SCAN_TICKS = 1 + 2 * LINES * SLOT + TAIL;
    localparam int WAIT_CLKS  = 8 * SCAN_TICKS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ph = 1'b0;
    logic [1:0] sleep_sel = 2'd0;
    logic [1:0] line_cfg = 2'd0;
    logic read_done = 1'b0;
    logic [KEYS-1:0] keys = '0;
    logic [SENSES-1:0] sense;
    logic osc_tick;
    logic [LINES-1:0] drive_out, drive_en;
    logic [KEYS-1:0] key_image;
    logic key_ready_n, wake_req;
    int ticks = 0;
    int n_tests = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(negedge clk) ph <= ~ph;
    assign osc_tick = ph && ((sleep_sel == 2'd0) || wake_req);
    always @(posedge clk) if (osc_tick) ticks <= ticks + 1;

    // Matrix model: a pressed key joins its drive line to its sense line.
    always_comb begin
        sense = '0;
        for (int i = 0; i < LINES; i++)
            for (int j = 0; j < SENSES; j++)
                if (drive_out[i] && keys[i * SENSES + j]) sense[j] = 1'b1;
    end

    keymat_scanner #(
        .LINES(LINES), .SENSES(SENSES), .SLOT_TICKS(SLOT),
        .SETTLE_TICKS(SETTLE), .TAIL_TICKS(TAIL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .sleep_sel(sleep_sel),
        .line_cfg(line_cfg), .read_done(read_done), .sense_in(sense),
        .drive_out(drive_out), .drive_en(drive_en), .key_image(key_image),
        .key_ready_n(key_ready_n), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until_ticks(input int t0, input int n);
        while (ticks - t0 < n) @(negedge clk);
    endtask

    task automatic wait_ready(output bit seen);
        seen = 1'b0;
        for (int c = 0; c < WAIT_CLKS && !seen; c++) begin
            @(negedge clk);
            if (!key_ready_n) seen = 1'b1;
        end
    endtask

    task automatic do_read();
        @(negedge clk) read_done = 1'b1;
        @(negedge clk) read_done = 1'b0;
    endtask

    task automatic release_keys();
        keys = '0;
        wait_clks(2);
        if (!key_ready_n) do_read();
        wait_clks(4);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wait_clks(4);
        rst_n = 1'b1;
        wait_clks(1);
    endtask

    // Press a set of keys and expect a capture of exp.
    task automatic capture(input string req, input logic [KEYS-1:0] press, input logic [KEYS-1:0] exp);
        bit seen;
        keys = press;
        wait_ready(seen);
        chk({req, " ready"}, seen, 1'b1);
        chk({req, " image"}, key_image, exp);
        release_keys();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit seen;
        int t0;
        logic [LINES-1:0] pat, en;

        @(negedge clk);
        do_reset();
        // R11: reset state
        chk("R11 image after reset", key_image, 0);
        chk("R11 ready after reset", key_ready_n, 1);
        chk("R11 idle drive", drive_out, 6'h3f);
        chk("R9 no wake in normal", wake_req, 0);

        // R8 / R10: standby levels over every mode and line configuration
        for (int s = 0; s < 4; s++) begin
            for (int c = 0; c < 4; c++) begin
                sleep_sel = 2'(s);
                line_cfg  = 2'(c);
                wait_clks(1);
                pat = (s == 1) ? 6'b100000 : (s == 2) ? 6'b110000 : 6'b111111;
                en  = (c == 0) ? 6'b111111 : (c == 1) ? 6'b111110 : 6'b111100;
                chk("R8 standby pattern", drive_out, pat & en);
                chk("R10 line enable", drive_en, en);
            end
        end
        sleep_sel = 2'd0;
        line_cfg  = 2'd0;
        wait_clks(2);

        // R1 / R2: exact scan length and sweep order
        keys = KEYS'(1) << 7;
        t0 = ticks;
        for (int sl = 0; sl < 2 * LINES; sl++) begin
            wait_until_ticks(t0, 2 + SLOT * sl);
            chk("R2 sweep line order", drive_out, 6'(1) << (sl % LINES));
        end
        wait_until_ticks(t0, 2 + 2 * LINES * SLOT);
        chk("R2 tail drives low", drive_out, 0);
        wait_ready(seen);
        chk("R1 scan tick count", ticks - t0, SCAN_TICKS);
        chk("R4 capture image", key_image, KEYS'(1) << 7);
        keys = '0;
        do_read();
        chk("R6 read releases ready", key_ready_n, 1);
        wait_clks(4);

        // R7: every key alone, bit position from drive and sense line
        for (int k = 0; k < KEYS; k++) begin
            int ln, sn;
            ln = k / SENSES;
            sn = k % SENSES;
            capture("R7 single key", KEYS'(1) << k, KEYS'(1) << (SENSES * ln + sn));
        end

        // R4: several keys at once
        capture("R4 diagonal", 30'h0000_0000 | (30'(1) << 0) | (30'(1) << 6) | (30'(1) << 12)
                | (30'(1) << 18) | (30'(1) << 24) | (30'(1) << 25),
                (30'(1) << 0) | (30'(1) << 6) | (30'(1) << 12) | (30'(1) << 18)
                | (30'(1) << 24) | (30'(1) << 25));
        capture("R4 all keys", {KEYS{1'b1}}, {KEYS{1'b1}});
        capture("R4 one sense column", 30'b00001_00001_00001_00001_00001_00001,
                30'b00001_00001_00001_00001_00001_00001);

        // R5: locked buffer ignores key changes; R6 read re-arms scanning
        keys = KEYS'(1) << 3;
        wait_ready(seen);
        keys = (KEYS'(1) << 3) | (KEYS'(1) << 20);
        wait_clks(4 * SCAN_TICKS);
        chk("R5 ready held while locked", key_ready_n, 0);
        chk("R5 image held while locked", key_image, KEYS'(1) << 3);
        do_read();
        wait_ready(seen);
        chk("R6 rescan after read", key_image, (KEYS'(1) << 3) | (KEYS'(1) << 20));
        release_keys();

        // R6: read strobe while unlocked has no effect
        do_read();
        wait_clks(4);
        chk("R6 stray read keeps ready", key_ready_n, 1);
        chk("R6 stray read keeps image", key_image, (KEYS'(1) << 3) | (KEYS'(1) << 20));

        // R1: press shorter than a scan is not captured
        keys = KEYS'(1) << 0;
        t0 = ticks;
        wait_until_ticks(t0, 10);
        keys = '0;
        wait_clks(4 * SCAN_TICKS);
        chk("R1 short press ignored", key_ready_n, 1);

        // R3: mismatch between sweeps forces exactly one retry
        keys = KEYS'(1) << 1;
        t0 = ticks;
        wait_until_ticks(t0, 2 + LINES * SLOT);
        keys = (KEYS'(1) << 1) | (KEYS'(1) << 2);
        wait_ready(seen);
        chk("R3 retry tick count", ticks - t0, 2 * SCAN_TICKS);
        chk("R3 retry image", key_image, (KEYS'(1) << 1) | (KEYS'(1) << 2));
        release_keys();

        // R10: lines lent to segment duty are not scanned
        line_cfg = 2'd1;
        keys = KEYS'(1) << 0;
        wait_clks(4 * SCAN_TICKS);
        chk("R10 lent line no scan", key_ready_n, 1);
        capture("R10 line 1 masked", (KEYS'(1) << 0) | (KEYS'(1) << 12), KEYS'(1) << 12);
        line_cfg = 2'd2;
        capture("R10 lines 1-2 masked", (KEYS'(1) << 7) | (KEYS'(1) << 29), KEYS'(1) << 29);
        line_cfg = 2'd0;
        wait_clks(2);

        // R8 / R9: sleep wake only from keys on armed standby lines
        for (int s = 1; s < 4; s++) begin
            sleep_sel = 2'(s);
            for (int ln = 0; ln < LINES; ln++) begin
                bit armed;
                armed = (s == 3) || (s == 2 && ln >= LINES - 2) || (s == 1 && ln == LINES - 1);
                keys = KEYS'(1) << (SENSES * ln + 4);
                wait_clks(20);
                chk("R9 wake request", wake_req, armed);
                if (armed) begin
                    wait_ready(seen);
                    chk("R9 sleep capture", key_image, KEYS'(1) << (SENSES * ln + 4));
                    chk("R9 wake drops after scan", wake_req, 0);
                end else begin
                    wait_clks(4 * SCAN_TICKS);
                    chk("R8 unarmed line no scan", key_ready_n, 1);
                end
                release_keys();
            end
        end
        sleep_sel = 2'd0;
        wait_clks(2);

        // R11: reset clears a locked buffer
        keys = KEYS'(1) << 17;
        wait_ready(seen);
        keys = '0;
        do_reset();
        chk("R11 reset clears image", key_image, 0);
        chk("R11 reset releases ready", key_ready_n, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule